// File: doc/BRIEF.md
# Power Management Status and Wake Controller

This block gathers the power-management status of a chip into two byte-wide status registers on a plain I/O bus. The bus has an address, a write strobe, a read strobe and an 8-bit data path. A free-running counter marks the passing of time. Each time the counter's top bit turns over, a timer status flag is raised. When software has enabled the timer, that flag holds a level power-management event output until software clears it.

Two more flags follow their companion control bits. A bus-master flag is raised when its control bit is written to 1. A global flag is raised when the firmware-release bit is written to 1. Clearing either flag also drops its companion control bit.

A wake flag drives a two-state machine with a sleeping state and a working state. An enabled resume event that arrives while the machine sleeps sets the flag and returns the machine to work. The flag is cleared by software or by an expiry pulse from an external standby timer. Once the flag is clear and an external input reports that every device is asleep, the machine goes back to sleep.

The block has four registers, at offsets 0 to 3 from a base address:

| Offset | Register | Fields |
|---|---|---|
| +0 | first status register | bit 0 timer, bit 4 bus-master, bit 5 global |
| +1 | second status register | bit 7 wake |
| +2 | control register | bit 0 timer enable, bit 1 bus-master control, bit 2 firmware release |
| +3 | resume-enable mask | one bit per resume source, in bits `[RES_W-1:0]` |

Top module: `pm_wake_ctrl`

## Requirements
- R1: The first status register, at BASE_ADDR, holds the timer flag in bit 0, the bus-master flag in bit 4 and the global flag in bit 5. Its bits 1-3 and 6-7 always read 0, even after a write of 1 to them. `io_rdata` shows the addressed register in the same cycle as `io_rd` and reads 0 otherwise.
- R2: The second status register, at BASE_ADDR+1, holds the wake flag in bit 7, and its bits 0-6 read 0. The control register at BASE_ADDR+2 holds the timer enable in bit 0, the bus-master control in bit 1 and the firmware release in bit 2, and reads back as written. The resume-enable mask at BASE_ADDR+3 uses bits `[RES_W-1:0]`.
- R3: Reset clears the counter and every status, control and mask bit. The machine leaves reset working, with `asleep`=0 and `pme`=0.
- R4: The counter advances by 1 on every clock. The timer flag is set at each clock edge where the counter's top bit changes, both from 0 to 1 and from 1 to 0.
- R5: `pme` is high exactly while the timer enable and the timer flag are both 1.
- R6: Each status flag is cleared by writing 1 to its bit. Writing 0 to its bit leaves it unchanged.
- R7: Writing 1 to the bus-master control bit also sets the bus-master flag. Writing 1 to the bus-master flag clears both the flag and the control bit.
- R8: Writing 1 to the firmware-release bit sets the global flag. Writing 1 to the global flag clears both the flag and the firmware-release bit.
- R9: While asleep, a `resume_evt` bit whose mask bit is 1 sets the wake flag and moves the machine to working at the same edge. A resume bit whose mask bit is 0 has no effect.
- R10: A `standby_exp` pulse clears the wake flag.
- R11: When the machine is working, the wake flag is 0 and `all_asleep` is 1, the machine enters the sleeping state at the next edge. While the wake flag is 1, the machine stays working.
- R12: When a hardware set and a clear reach the same flag in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| resume_evt | input | RES_W | Resume event sources, one bit each |
| standby_exp | input | 1 | Pulse from the global standby timer on expiry |
| all_asleep | input | 1 | High when every device reports sleeping |
| pme | output | 1 | Level power-management event |
| asleep | output | 1 | 1 in the sleeping state, 0 in the working state |

## Verification
The assertions assume that every input is held stable for a whole clock cycle. They also assume that a write strobe lasts one cycle and targets a single register. The check that a write of 0 leaves the wake flag alone excludes cycles with a standby-expiry pulse, because that pulse may clear the flag on its own. The bench changes inputs only on falling edges and raises `io_wr` for one cycle per access. It tracks the counter phase with its own edge count, so that writes aimed at a top-bit turnover land on exactly that edge.

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400,
  parameter int CNT_W = 24,
  parameter int RES_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [RES_W-1:0]  resume_evt,
  input  logic              standby_exp,
  input  logic              all_asleep,
  output logic              pme,
  output logic              asleep
);
  localparam logic [ADDR_W-1:0] A_STS2 = BASE_ADDR + 1'b1;
  localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR + 2'd2;
  localparam logic [ADDR_W-1:0] A_REN  = BASE_ADDR + 2'd3;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [RES_W-1:0] res_en;
  logic tmr_sts, bm_sts, gbl_sts, wak_sts;
  logic tmr_en, bm_ctl, fw_rel;

  assign cnt_nxt = cnt + 1'b1;
  wire msb_flip = cnt_nxt[CNT_W-1] ^ cnt[CNT_W-1];

  wire wr_s1 = io_wr && (io_addr == BASE_ADDR);
  wire wr_s2 = io_wr && (io_addr == A_STS2);
  wire wr_ct = io_wr && (io_addr == A_CTRL);
  wire wr_re = io_wr && (io_addr == A_REN);

  wire wake_set = asleep && |(resume_evt & res_en);
  wire wake_clr = (wr_s2 && io_wdata[7]) || standby_exp;

  assign pme = tmr_en & tmr_sts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      res_en  <= '0;
      tmr_sts <= 1'b0;
      bm_sts  <= 1'b0;
      gbl_sts <= 1'b0;
      wak_sts <= 1'b0;
      tmr_en  <= 1'b0;
      bm_ctl  <= 1'b0;
      fw_rel  <= 1'b0;
      asleep  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;

      if (msb_flip)                      tmr_sts <= 1'b1;
      else if (wr_s1 && io_wdata[0])     tmr_sts <= 1'b0;

      if (wr_ct) begin
        tmr_en <= io_wdata[0];
        bm_ctl <= io_wdata[1];
        fw_rel <= io_wdata[2];
      end

      if (wr_ct && io_wdata[1]) bm_sts <= 1'b1;
      else if (wr_s1 && io_wdata[4]) begin
        bm_sts <= 1'b0;
        bm_ctl <= 1'b0;
      end

      if (wr_ct && io_wdata[2]) gbl_sts <= 1'b1;
      else if (wr_s1 && io_wdata[5]) begin
        gbl_sts <= 1'b0;
        fw_rel  <= 1'b0;
      end

      if (wr_re) res_en <= io_wdata[RES_W-1:0];

      if (wake_set)      wak_sts <= 1'b1;
      else if (wake_clr) wak_sts <= 1'b0;

      if (wake_set)                            asleep <= 1'b0;
      else if (!asleep && !wak_sts && all_asleep) asleep <= 1'b1;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (io_addr == BASE_ADDR)   io_rdata = {2'b00, gbl_sts, bm_sts, 3'b000, tmr_sts};
      else if (io_addr == A_STS2) io_rdata = {wak_sts, 7'b0};
      else if (io_addr == A_CTRL) io_rdata = {5'b0, fw_rel, bm_ctl, tmr_en};
      else if (io_addr == A_REN)  io_rdata = 8'(res_en);
    end
  end

  assert_tmr_on_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[CNT_W-1] != $past(cnt[CNT_W-1])) |-> tmr_sts);

  assert_bm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ct && io_wdata[1]) |=> (bm_sts && bm_ctl));

  assert_wake_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && |(resume_evt & res_en)) |=> (wak_sts && !asleep));

  assert_w0_keeps_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wak_sts && !standby_exp && !(wr_s2 && io_wdata[7])) |=> wak_sts);

  assert_sleep_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !wak_sts && all_asleep) |=> asleep);

  assert_no_sleep_while_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && wak_sts) |=> !asleep);
endmodule

// File: tb/tb_pm_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pm_wake_ctrl;
  localparam logic [15:0] BASE = 16'h0400;
  localparam int CW = 6;
  localparam int HALF = 1 << (CW - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [3:0] resume_evt = '0;
  logic standby_exp = 1'b0, all_asleep = 1'b0;
  logic pme, asleep;
  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] rv;

  pm_wake_ctrl #(.ADDR_W(16), .BASE_ADDR(BASE), .CNT_W(CW), .RES_W(4)) dut (
    .clk, .rst_n, .io_addr, .io_wr, .io_rd, .io_wdata, .io_rdata,
    .resume_evt, .standby_exp, .all_asleep, .pme, .asleep);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  // [22:19] req, [18] write, [17:16] offset, [15:8] data/expected, [7:0] compare mask
  localparam logic [22:0] VEC [0:18] = '{
    {4'd7, 1'b1, 2'd2, 8'h02, 8'h00},  // R7 set bus-master control
    {4'd7, 1'b0, 2'd0, 8'h10, 8'hFE},
    {4'd2, 1'b0, 2'd2, 8'h02, 8'hFF},  // R2 control readback
    {4'd6, 1'b1, 2'd0, 8'h00, 8'h00},  // R6 write zero
    {4'd6, 1'b0, 2'd0, 8'h10, 8'hFE},
    {4'd7, 1'b1, 2'd0, 8'h10, 8'h00},  // R7 clear flag
    {4'd7, 1'b0, 2'd0, 8'h00, 8'hFE},
    {4'd7, 1'b0, 2'd2, 8'h00, 8'hFF},
    {4'd8, 1'b1, 2'd2, 8'h04, 8'h00},  // R8 firmware release
    {4'd8, 1'b0, 2'd0, 8'h20, 8'hFE},
    {4'd8, 1'b0, 2'd2, 8'h04, 8'hFF},
    {4'd8, 1'b1, 2'd0, 8'h20, 8'h00},
    {4'd8, 1'b0, 2'd0, 8'h00, 8'hFE},
    {4'd8, 1'b0, 2'd2, 8'h00, 8'hFF},
    {4'd2, 1'b1, 2'd3, 8'h05, 8'h00},  // R2 resume mask
    {4'd2, 1'b0, 2'd3, 8'h05, 8'hFF},
    {4'd1, 1'b1, 2'd0, 8'hCE, 8'h00},  // R1 reserved bits
    {4'd1, 1'b0, 2'd0, 8'h00, 8'hFE},
    {4'd2, 1'b0, 2'd1, 8'h00, 8'hFF}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] off, input logic [7:0] d);
    io_addr = BASE + 16'(off); io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] off, output logic [7:0] d);
    io_addr = BASE + 16'(off); io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic wait_phase(input int p);
    while (cyc % HALF != p) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    for (int k = 0; k < 4; k++) begin
      rd_reg(2'(k), rv); check("R3 reg after reset", rv, 0);
    end
    check("R3 asleep after reset", asleep, 0);
    check("R3 pme after reset", pme, 0);
    #1 check("R1 rdata idle", io_rdata, 0);

    for (int i = 0; i < 19; i++) begin
      if (VEC[i][18]) wr_reg(VEC[i][17:16], VEC[i][15:8]);
      else begin
        rd_reg(VEC[i][17:16], rv);
        tests++;
        if ((rv & VEC[i][7:0]) != (VEC[i][15:8] & VEC[i][7:0])) begin
          fails++;
          $display("FAIL R%0d vector %0d: got %0h expected %0h", VEC[i][22:19], i,
                   rv & VEC[i][7:0], VEC[i][15:8] & VEC[i][7:0]);
        end
      end
    end

    // R4 timer status on rising and falling top-bit change
    for (int n = 0; n < 2; n++) begin
      wait_phase(0);
      rd_reg(0, rv); check("R4 timer flag after flip", rv[0], 1);
      wr_reg(0, 8'h01);
      rd_reg(0, rv); check("R6 timer flag cleared", rv[0], 0);
      wait_phase(HALF - 1);
      rd_reg(0, rv); check("R4 timer flag before flip", rv[0], 0);
      step();
      rd_reg(0, rv); check("R4 timer flag on flip", rv[0], 1);
    end
    // R12 clear on the flip edge loses
    wr_reg(0, 8'h01);
    wait_phase(HALF - 1);
    wr_reg(0, 8'h01);
    rd_reg(0, rv); check("R12 timer set beats clear", rv[0], 1);

    // R5 event output
    wr_reg(2, 8'h01);
    check("R5 pme enabled with flag", pme, 1);
    wr_reg(0, 8'h01);
    check("R5 pme after clear", pme, 0);
    wr_reg(2, 8'h00);
    wait_phase(0);
    rd_reg(0, rv); check("R4 flag set while disabled", rv[0], 1);
    check("R5 pme disabled", pme, 0);

    // R11 / R9 / R10 wake machine, resume mask = 0x5
    all_asleep = 1'b1; step(); all_asleep = 1'b0;
    check("R11 enter sleep", asleep, 1);
    resume_evt = 4'h2; step(); resume_evt = '0;
    rd_reg(1, rv); check("R9 masked resume ignored", rv, 8'h00);
    check("R9 masked resume stays asleep", asleep, 1);
    resume_evt = 4'h4; step(); resume_evt = '0;
    rd_reg(1, rv); check("R9 wake flag set", rv, 8'h80);
    check("R9 back to working", asleep, 0);
    all_asleep = 1'b1; step();
    check("R11 held awake by wake flag", asleep, 0);
    wr_reg(1, 8'h7F);
    rd_reg(1, rv); check("R6 wake write zero", rv, 8'h80);
    standby_exp = 1'b1; step(); standby_exp = 1'b0;
    rd_reg(1, rv); check("R10 standby clears wake", rv, 8'h00);
    check("R11 not asleep yet", asleep, 0);
    step(); all_asleep = 1'b0;
    check("R11 sleep after wake clear", asleep, 1);
    resume_evt = 4'h1; standby_exp = 1'b1;
    wr_reg(1, 8'h80);
    resume_evt = '0; standby_exp = 1'b0;
    rd_reg(1, rv); check("R12 wake set beats clears", rv, 8'h80);
    check("R9 awake after collision", asleep, 0);
    wr_reg(1, 8'h80);
    rd_reg(1, rv); check("R6 wake write one clears", rv, 8'h00);

    // R3 mid-run reset
    wr_reg(2, 8'h07);
    rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    rd_reg(0, rv); check("R3 status1 after reset", rv, 0);
    rd_reg(2, rv); check("R3 control after reset", rv, 0);
    rd_reg(3, rv); check("R3 mask after reset", rv, 0);
    summary();
  end
endmodule